// File: doc/BRIEF.md
# Per-Sector ECC Status Decoder

After a page has been read from flash, the error-correction engine leaves a small error count for every 512-byte data sector of the page buffer, and packs four counts into each 32-bit status word. This block reads the counts for one page and sums the corrected errors. It also decides whether the page holds an uncorrectable sector. A count of 15 is the uncorrectable code. The block stops scanning at the first such sector.

An uncorrectable code on an erased page is not a real failure, because the spare-area check bytes of an erased page are all 0xFF and do not decode. For that reason the block also watches the page bytes as they stream past. Each byte carries two flags: one marks a main-area byte and one marks a check-byte position in the spare area. The uncorrectable verdict is raised only when some flagged byte differs from 0xFF.

A decode begins with a start pulse. The pulse captures the status words, the buffer number and the sector count. The sector scan (one sector per clock) and the byte stream run side by side. A single-cycle done strobe marks the moment when both have finished.

Top module: `ecc_sector_decoder`

## Requirements
- R1: While reset is held, and after it is released, `done`, `uncorrectable` and `corr_total` are all 0.
- R2: The count for sector n is bits [3:0] of byte lane (3 - n mod 4) of status word n/4. Word w occupies bits [32w+31:32w] of `status_words`. Sector 0 therefore sits in bits [27:24], sector 3 in bits [3:0] and sector 4 in bits [59:56].
- R3: A decode examines sectors `buf_num*sectors_per_page` up to `buf_num*sectors_per_page + sectors_per_page - 1`, in ascending order, one per clock. The counts of all other sectors have no effect. The range is assumed to lie inside the status words, and `sectors_per_page` is assumed to be at least 1.
- R4: `corr_total` is cleared by an accepted start. Every examined count below 15 is added to it.
- R5: `corr_total` saturates at 2^CNT_W - 1 and never wraps.
- R6: A count of 15 ends the scan. Neither it nor any later sector is added.
- R7: When the decode completes, `uncorrectable` is set when the scan met a count of 15 and at least one byte accepted with `byte_is_main` or `byte_is_ecc` set differs from 0xFF. Bytes with neither flag set do not count.
- R8: `done` is high for exactly one cycle: the cycle after the later of two events, the last examined sector or the byte presented with `byte_last`. Bytes are accepted from the cycle after start.
- R9: `corr_total` and `uncorrectable` hold their values from done until the next accepted start. A start during a decode, and bytes presented outside a decode, are ignored.
- R10: The status words, buffer number and sector count are sampled at the accepted start. Later changes to those inputs do not alter the running decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode (ignored while one runs) |
| status_words | input | 32*NUM_WORDS | Packed per-sector error counts |
| buf_num | input | BUF_W | Page buffer number |
| sectors_per_page | input | SPP_W | Sectors in one page |
| byte_valid | input | 1 | Page byte present this cycle |
| byte_data | input | 8 | Page byte |
| byte_is_main | input | 1 | Byte lies in the main data area |
| byte_is_ecc | input | 1 | Byte lies at a check-byte position of the spare area |
| byte_last | input | 1 | Final byte of the page stream |
| corr_total | output | CNT_W | Saturating corrected-error total |
| uncorrectable | output | 1 | Page read has an uncorrectable error |
| done | output | 1 | Decode complete strobe |

## Verification
The bench drives pages in which the scan finishes before the byte stream, and pages in which it finishes after. A design that timed `done` from only one of the two events would pulse too early in one of these cases. Several pages carry an uncorrectable code, and these pages differ in how clean they are. One is fully erased but has a zero in an unflagged spare byte, one has a dirty main byte, and one has a dirty check byte. A decoder that ignored the blank test, or that tested the wrong bytes, would set the wrong verdict on one of them. The sector ranges are offset by the buffer number, and the neighbouring sectors are loaded with large counts. A lane or word mix-up therefore shows up as a wrong total. A narrow-counter instance is driven past its ceiling, so a counter that wraps is caught. Changing the status words just after start, and pulsing start again mid-decode, show whether the inputs are sampled only once.

// File: rtl/ecc_dec_pkg.sv
package ecc_dec_pkg;
  localparam int          NIB_W          = 4;
  localparam int          LANES_PER_WORD = 4;
  localparam int          WORD_W         = 32;
  localparam logic [3:0]  UNCORR_CODE    = 4'hF;
  localparam logic [7:0]  ERASED_BYTE    = 8'hFF;
endpackage

// File: rtl/ecc_nibble_sel.sv
module ecc_nibble_sel
  import ecc_dec_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int IDX_W     = 4
) (
  input  logic [WORD_W*NUM_WORDS-1:0] words,
  input  logic [IDX_W-1:0]            idx,
  output logic [NIB_W-1:0]            nib
);
  localparam int NUM_SECT = NUM_WORDS * LANES_PER_WORD;
  localparam int IDX_SPAN = 1 << IDX_W;

  logic [NIB_W-1:0] nib_arr [IDX_SPAN];

  // lowest sector of each word lives in its top byte lane
  for (genvar s = 0; s < IDX_SPAN; s++) begin : g_sect
    if (s < NUM_SECT) begin : g_live
      assign nib_arr[s] = words[(s / LANES_PER_WORD) * WORD_W
                                + (LANES_PER_WORD - 1 - (s % LANES_PER_WORD)) * 8 +: NIB_W];
    end else begin : g_pad
      assign nib_arr[s] = '0;
    end
  end

  assign nib = nib_arr[idx];
endmodule

// File: rtl/ecc_scan_ctrl.sv
module ecc_scan_ctrl
  import ecc_dec_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int IDX_W     = 4,
  parameter int BUF_W     = 2,
  parameter int SPP_W     = 5,
  parameter int CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_go,
  input  logic [WORD_W*NUM_WORDS-1:0] words_in,
  input  logic [BUF_W-1:0]            buf_num,
  input  logic [SPP_W-1:0]            spp,
  output logic                        busy,
  output logic                        end_now,
  output logic                        unc_hit_d,
  output logic [CNT_W-1:0]            total
);
  localparam int         PW      = BUF_W + SPP_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WORD_W*NUM_WORDS-1:0] words_q, words_d;
  logic [IDX_W-1:0]            cur_q, cur_d, last_q, last_d;
  logic                        busy_q, busy_d, unc_q;
  logic [CNT_W-1:0]            total_q, total_d;
  logic [PW-1:0]               first_w, last_w;
  logic [NIB_W-1:0]            nib;
  logic [CNT_W:0]              sum;

  ecc_nibble_sel #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_sel (
    .words (words_q),
    .idx   (cur_q),
    .nib   (nib)
  );

  assign first_w = PW'(buf_num) * PW'(spp);
  assign last_w  = first_w + PW'(spp) - PW'(1);
  assign sum     = {1'b0, total_q} + {{(CNT_W + 1 - NIB_W){1'b0}}, nib};

  always_comb begin
    words_d   = words_q;
    cur_d     = cur_q;
    last_d    = last_q;
    busy_d    = busy_q;
    total_d   = total_q;
    unc_hit_d = unc_q;
    end_now   = 1'b0;
    if (start_go) begin
      words_d   = words_in;
      cur_d     = first_w[IDX_W-1:0];
      last_d    = last_w[IDX_W-1:0];
      busy_d    = 1'b1;
      total_d   = '0;
      unc_hit_d = 1'b0;
    end else if (busy_q) begin
      if (nib == UNCORR_CODE) begin
        unc_hit_d = 1'b1;
        busy_d    = 1'b0;
        end_now   = 1'b1;
      end else begin
        total_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        if (cur_q == last_q) begin
          busy_d  = 1'b0;
          end_now = 1'b1;
        end else begin
          cur_d = cur_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      cur_q   <= '0;
      last_q  <= '0;
      busy_q  <= 1'b0;
      total_q <= '0;
      unc_q   <= 1'b0;
    end else begin
      words_q <= words_d;
      cur_q   <= cur_d;
      last_q  <= last_d;
      busy_q  <= busy_d;
      total_q <= total_d;
      unc_q   <= unc_hit_d;
    end
  end

  assign busy  = busy_q;
  assign total = total_q;
endmodule

// File: rtl/erased_page_detect.sv
module erased_page_detect
  import ecc_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_go,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       byte_is_main,
  input  logic       byte_is_ecc,
  input  logic       byte_last,
  output logic       busy,
  output logic       end_now,
  output logic       blank_d
);
  logic busy_q, busy_d, blank_q;
  logic take, dirty;

  assign take  = busy_q && byte_valid;
  assign dirty = (byte_data != ERASED_BYTE) && (byte_is_main || byte_is_ecc);

  always_comb begin
    busy_d  = busy_q;
    blank_d = blank_q;
    end_now = 1'b0;
    if (start_go) begin
      busy_d  = 1'b1;
      blank_d = 1'b1;
    end else if (take) begin
      if (dirty) blank_d = 1'b0;
      if (byte_last) begin
        busy_d  = 1'b0;
        end_now = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      busy_q  <= busy_d;
      blank_q <= blank_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/ecc_sector_decoder.sv
module ecc_sector_decoder
  import ecc_dec_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int BUF_W     = 2,
  parameter int SPP_W     = 5,
  parameter int CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [WORD_W*NUM_WORDS-1:0] status_words,
  input  logic [BUF_W-1:0]            buf_num,
  input  logic [SPP_W-1:0]            sectors_per_page,
  input  logic                        byte_valid,
  input  logic [7:0]                  byte_data,
  input  logic                        byte_is_main,
  input  logic                        byte_is_ecc,
  input  logic                        byte_last,
  output logic [CNT_W-1:0]            corr_total,
  output logic                        uncorrectable,
  output logic                        done
);
  localparam int IDX_W = $clog2(NUM_WORDS * LANES_PER_WORD);

  logic pend_q, pend_d, done_q, unc_q, unc_d;
  logic start_go, finish;
  logic scan_busy, scan_end, scan_unc_d;
  logic strm_busy, strm_end, blank_d;

  assign start_go = start && !pend_q;

  ecc_scan_ctrl #(
    .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .BUF_W(BUF_W),
    .SPP_W(SPP_W), .CNT_W(CNT_W)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_go  (start_go),
    .words_in  (status_words),
    .buf_num   (buf_num),
    .spp       (sectors_per_page),
    .busy      (scan_busy),
    .end_now   (scan_end),
    .unc_hit_d (scan_unc_d),
    .total     (corr_total)
  );

  erased_page_detect u_blank (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_go     (start_go),
    .byte_valid   (byte_valid),
    .byte_data    (byte_data),
    .byte_is_main (byte_is_main),
    .byte_is_ecc  (byte_is_ecc),
    .byte_last    (byte_last),
    .busy         (strm_busy),
    .end_now      (strm_end),
    .blank_d      (blank_d)
  );

  assign finish = pend_q && (!scan_busy || scan_end) && (!strm_busy || strm_end);

  always_comb begin
    pend_d = pend_q;
    unc_d  = unc_q;
    if (start_go) begin
      pend_d = 1'b1;
      unc_d  = 1'b0;
    end else if (finish) begin
      pend_d = 1'b0;
      unc_d  = scan_unc_d && !blank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      unc_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= finish;
      unc_q  <= unc_d;
    end
  end

  assign done          = done_q;
  assign uncorrectable = unc_q;
endmodule

// File: rtl/ecc_sector_decoder_checker.sv
module ecc_sector_decoder_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             uncorrectable,
  input logic [CNT_W-1:0] corr_total
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_verdict_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorrectable != $past(uncorrectable)) |-> (done || $past(start)));

  assert_flag_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uncorrectable) |-> done);

  assert_total_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_total != $past(corr_total)) |-> ((corr_total > $past(corr_total)) || $past(start)));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(corr_total) == CNT_MAX) && !$past(start)) |-> (corr_total == CNT_MAX));
endmodule

bind ecc_sector_decoder ecc_sector_decoder_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .done          (done),
  .uncorrectable (uncorrectable),
  .corr_total    (corr_total)
);

// File: tb/ecc_sector_decoder_test.sv
`timescale 1ns/1ps
module ecc_sector_decoder_test;
  localparam int NW = 4;
  localparam int SAT_W = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [127:0] status_words;
  logic [1:0]   buf_num;
  logic [4:0]   sectors_per_page;
  logic         byte_valid, byte_is_main, byte_is_ecc, byte_last;
  logic [7:0]   byte_data;
  logic [15:0]  total_a;
  logic [SAT_W-1:0] total_b;
  logic         unc_a, unc_b, done_a, done_b;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ecc_sector_decoder #(.NUM_WORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .status_words(status_words),
    .buf_num(buf_num), .sectors_per_page(sectors_per_page),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_main(byte_is_main),
    .byte_is_ecc(byte_is_ecc), .byte_last(byte_last),
    .corr_total(total_a), .uncorrectable(unc_a), .done(done_a));

  ecc_sector_decoder #(.NUM_WORDS(NW), .CNT_W(SAT_W)) uut_sat (
    .clk(clk), .rst_n(rst_n), .start(start), .status_words(status_words),
    .buf_num(buf_num), .sectors_per_page(sectors_per_page),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_main(byte_is_main),
    .byte_is_ecc(byte_is_ecc), .byte_last(byte_last),
    .corr_total(total_b), .uncorrectable(unc_b), .done(done_b));

  int nibs [16];
  logic [7:0] bq [$];
  bit mq [$];
  bit eq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [127:0] pack_words();
    logic [127:0] w = '0;
    for (int n = 0; n < 16; n++)
      w[(n / 4) * 32 + (3 - n % 4) * 8 +: 4] = 4'(nibs[n]);
    return w;
  endfunction

  task automatic build_page(input int dirty_kind);
    bq.delete(); mq.delete(); eq.delete();
    for (int i = 0; i < 8; i++) begin
      bq.push_back((dirty_kind == 1 && i == 3) ? 8'h12 : 8'hFF);
      mq.push_back(1'b1); eq.push_back(1'b0);
    end
    for (int i = 0; i < 2; i++) begin
      bq.push_back(8'h00); mq.push_back(1'b0); eq.push_back(1'b0);
    end
    for (int i = 0; i < 4; i++) begin
      bq.push_back((dirty_kind == 2 && i == 2) ? 8'h5A : 8'hFF);
      mq.push_back(1'b0); eq.push_back(1'b1);
    end
  endtask

  task automatic idle_bytes();
    byte_valid = 1'b0; byte_data = 8'h00; byte_is_main = 1'b0;
    byte_is_ecc = 1'b0; byte_last = 1'b0;
  endtask

  task automatic run_case(input int bnum, input int spp, input int gap,
                          input bit scramble, input bit restart, input bit post_idle,
                          input string req);
    int first, k, sum, npg, last_c, dcyc, lim, j, exp_a, exp_b, nxt;
    bit hit, blank;
    first = bnum * spp; k = 0; sum = 0; hit = 0; blank = 1;
    for (int n = first; n < first + spp; n++) begin
      k++;
      if (nibs[n] == 15) begin hit = 1; break; end
      sum += nibs[n];
    end
    for (int i = 0; i < bq.size(); i++)
      if ((mq[i] || eq[i]) && bq[i] != 8'hFF) blank = 0;
    npg = bq.size();
    last_c = 1 + (npg - 1) * (gap + 1);
    dcyc = ((k > last_c) ? k : last_c) + 1;
    exp_a = (sum > 65535) ? 65535 : sum;
    exp_b = (sum > 63) ? 63 : sum;
    lim = dcyc + 2;
    @(negedge clk);
    status_words = pack_words();
    buf_num = 2'(bnum); sectors_per_page = 5'(spp); start = 1'b1;
    idle_bytes();
    j = 0; nxt = 1;
    for (int c = 1; c <= lim; c++) begin
      @(negedge clk);
      chk(done_a == (c == dcyc), {req, " R8 done timing"}, int'(done_a), int'(c == dcyc));
      chk(done_b == (c == dcyc), {req, " R8 done timing (narrow)"}, int'(done_b), int'(c == dcyc));
      if (c >= dcyc) begin
        chk(total_a == 16'(exp_a), {req, " R4 total"}, int'(total_a), exp_a);
        chk(total_b == SAT_W'(exp_b), {req, " R5 saturated total"}, int'(total_b), exp_b);
        chk(unc_a == (hit && !blank), {req, " R7 verdict"}, int'(unc_a), int'(hit && !blank));
        chk(unc_b == unc_a, {req, " R7 verdict (narrow)"}, int'(unc_b), int'(unc_a));
      end
      start = restart && (c == 2);
      if (restart && c == 2) begin buf_num = 2'(bnum ^ 1); sectors_per_page = 5'd1; end
      if (scramble && c == 1) status_words = ~status_words;
      idle_bytes();
      if (j < npg && c == nxt) begin
        byte_valid = 1'b1; byte_data = bq[j]; byte_is_main = mq[j];
        byte_is_ecc = eq[j]; byte_last = (j == npg - 1);
        j++; nxt = c + gap + 1;
      end
    end
    if (post_idle) begin
      for (int c = 0; c < 4; c++) begin
        byte_valid = 1'b1; byte_data = 8'h00; byte_is_main = 1'b1; byte_last = (c == 3);
        @(negedge clk);
        chk(unc_a == (hit && !blank), {req, " R9 idle bytes keep verdict"}, int'(unc_a), int'(hit && !blank));
        chk(total_a == 16'(exp_a), {req, " R9 idle bytes keep total"}, int'(total_a), exp_a);
        chk(!done_a, {req, " R9 no done while idle"}, int'(done_a), 0);
      end
      idle_bytes();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; status_words = '0; buf_num = '0;
    sectors_per_page = 5'd1; idle_bytes();
    #1;
    chk(!done_a && !unc_a && total_a == 0, "R1 reset outputs", int'(total_a), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_a && !unc_a && total_a == 0, "R1 outputs after release", int'(unc_a), 0);

    // R2 R3 R4: buffer 0, 4 sectors, neighbours carry large counts
    for (int n = 0; n < 16; n++) nibs[n] = 13;
    nibs[0] = 1; nibs[1] = 2; nibs[2] = 3; nibs[3] = 4;
    build_page(0);
    run_case(0, 4, 0, 0, 0, 0, "R2 R3 lanes buf0");

    // R3 R6 R7: buffer 1, sector 6 uncorrectable, dirty main byte
    for (int n = 0; n < 16; n++) nibs[n] = 9;
    nibs[4] = 5; nibs[5] = 7; nibs[6] = 15; nibs[7] = 14;
    build_page(1);
    run_case(1, 4, 0, 0, 0, 1, "R6 R7 dirty main");

    // R7: same counts, erased page with a zero in a free spare byte
    build_page(0);
    run_case(1, 4, 1, 0, 0, 0, "R7 erased page");

    // R7: first sector uncorrectable, only a check byte dirty, slow stream
    for (int n = 0; n < 16; n++) nibs[n] = 2;
    nibs[12] = 15;
    build_page(2);
    run_case(3, 4, 2, 0, 0, 0, "R7 dirty check byte");

    // R5: whole status bank, all 14, short fast stream (scan ends last)
    for (int n = 0; n < 16; n++) nibs[n] = 14;
    bq.delete(); mq.delete(); eq.delete();
    bq.push_back(8'hFF); mq.push_back(1'b1); eq.push_back(1'b0);
    run_case(0, 16, 0, 0, 0, 0, "R5 saturation");

    // R9 R10: words scrambled after start, second start mid-decode
    for (int n = 0; n < 16; n++) nibs[n] = 1;
    nibs[4] = 6; nibs[5] = 8;
    build_page(1);
    run_case(2, 2, 1, 1, 1, 1, "R9 R10 capture");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule